// File: doc/BRIEF.md
# Interrupt Enable and Event Status Register

This block gathers up to eight event conditions into a single 16-bit register and turns them into one interrupt line for a host. A pulse on any event input latches a sticky status bit. The host programs a mask of per-event enables. The interrupt line is active while at least one latched event also has its enable set. A host can therefore wait for the line instead of polling the block.

The register is read through a simple port. Read data always shows the current register contents. A one-cycle read strobe marks a read by the host, and every status bit returned by that read is cleared at the next clock edge. An event that arrives in the same cycle as the strobe is still latched, so it is not lost. Writes change only the enable half of the register. A separate control input selects whether the line is active high or active low.

The line is driven by a two-state machine. `IRQ_IDLE` means no enabled event is pending and `IRQ_ACTIVE` means at least one is pending. The transition IDLE→ACTIVE (`raise`) is taken when the next register contents hold an enabled, latched event. The transition ACTIVE→IDLE (`drop`) is taken when they no longer do. In every other case the machine stays in its current state (`hold`).

Top module: `icsr_top`

## Requirements
- R1: After reset, the enable byte and the status byte are 0 and the state machine is idle. With `irq_pol_high`=0 this leaves `irq_o` at 1.
- R2: An event input high for one cycle sets status bit i (read data bit i) from the next clock edge onward, whatever the value of its enable.
- R3: A status bit stays set until a read strobe clears it. Showing read data without the strobe clears nothing.
- R4: Read data is {enables, status}: enable of event i at bit i+8 and status of event i at bit i. It is valid in the same cycle as `reg_rd`, and the returned status bits are 0 from the next edge.
- R5: An event that coincides with a read strobe leaves its status bit set after that edge.
- R6: A write loads `reg_wdata[15:8]` into the enables at the next edge. `reg_wdata[7:0]` has no effect on the status bits.
- R7: The interrupt is active from the edge at which some status bit and its enable are both 1. It is inactive from the edge at which no such pair remains.
- R8: With `irq_pol_high`=1 an active interrupt drives `irq_o`=1. With `irq_pol_high`=0 it drives `irq_o`=0. A change of polarity takes effect without waiting for a clock edge.
- R9: A status bit whose enable is 0 does not activate the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Event pulses, one bit per condition |
| reg_wr | input | 1 | Write strobe for the register |
| reg_wdata | input | 16 | Write data; only the upper byte is used |
| reg_rd | input | 1 | Read strobe; clears returned status bits |
| reg_rdata | output | 16 | Current register contents {enables, status} |
| irq_pol_high | input | 1 | 1 = active-high interrupt, 0 = active-low |
| irq_o | output | 1 | Interrupt line |

## Verification
Events, writes and clearing reads are registered once, so their effect on read data and on `irq_o` is due exactly one clock edge later. Read data and polarity changes are combinational and are due in the same cycle. The bench drives every input on the falling edge. It samples registered results on the next falling edge, after one rising edge has passed. It samples same-cycle results a nanosecond after the stimulus, before the rising edge. In this way each check looks at the cycle in which its result is due, and at no other cycle.

// File: rtl/icsr_pkg.sv
package icsr_pkg;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

endpackage

// File: rtl/icsr_enable_bank.sv
module icsr_enable_bank #(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_EVT-1:0] wr_bits,
    output logic [NUM_EVT-1:0] en_q,
    output logic [NUM_EVT-1:0] en_d
);

    logic [NUM_EVT-1:0] en_r;

    always_comb begin
        en_d = wr_en ? wr_bits : en_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_r <= '0;
        end else begin
            en_r <= en_d;
        end
    end

    assign en_q = en_r;

    // R6: a write lands in the enables one edge later
    assert_enable_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_q == $past(wr_bits)));

    // R6: no write, no change
    assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));

endmodule

// File: rtl/icsr_status_bank.sv
module icsr_status_bank #(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               rd_clr,
    output logic [NUM_EVT-1:0] st_q,
    output logic [NUM_EVT-1:0] st_d
);

    for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_bit
        logic bit_r;

        always_comb begin
            st_d[gi] = evt[gi] | (bit_r & ~rd_clr);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_r <= 1'b0;
            end else begin
                bit_r <= st_d[gi];
            end
        end

        assign st_q[gi] = bit_r;

        // R2: an event latches regardless of enable
        assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt[gi] |=> st_q[gi]);

        // R3: a latched bit survives cycles without a read strobe
        assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[gi] && !rd_clr) |=> st_q[gi]);

        // R4: a read with no new event clears the bit
        assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && !evt[gi]) |=> !st_q[gi]);

        // R5: an event coinciding with a read is kept
        assert_no_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && evt[gi]) |=> st_q[gi]);
    end

endmodule

// File: rtl/icsr_irq_fsm.sv
module icsr_irq_fsm
    import icsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pending_nxt,
    input  logic       pol_high,
    output irq_state_e state_q,
    output logic       irq_o
);

    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending_nxt)  state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (!pending_nxt) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_o = (state_q == IRQ_ACTIVE) ? pol_high : ~pol_high;
    end

    // R8: active level follows polarity control
    assert_active_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_ACTIVE) |-> (irq_o == pol_high));

    // R8: inactive level is the opposite
    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_IDLE) |-> (irq_o != pol_high));

endmodule

// File: rtl/icsr_top.sv
module icsr_top
    import icsr_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_EVT-1:0]     evt_i,
    input  logic                   reg_wr,
    input  logic [2*NUM_EVT-1:0]   reg_wdata,
    input  logic                   reg_rd,
    output logic [2*NUM_EVT-1:0]   reg_rdata,
    input  logic                   irq_pol_high,
    output logic                   irq_o
);

    localparam int REG_W = 2 * NUM_EVT;

    logic [NUM_EVT-1:0] en_q;
    logic [NUM_EVT-1:0] en_d;
    logic [NUM_EVT-1:0] st_q;
    logic [NUM_EVT-1:0] st_d;
    logic               pending_nxt;
    logic               wdata_unused_lo;
    irq_state_e         irq_state;

    assign wdata_unused_lo = ^reg_wdata[NUM_EVT-1:0];

    icsr_enable_bank #(.NUM_EVT(NUM_EVT)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_bits (reg_wdata[REG_W-1:NUM_EVT]),
        .en_q    (en_q),
        .en_d    (en_d)
    );

    icsr_status_bank #(.NUM_EVT(NUM_EVT)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_i),
        .rd_clr (reg_rd),
        .st_q   (st_q),
        .st_d   (st_d)
    );

    assign pending_nxt = |(st_d & en_d);

    icsr_irq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending_nxt (pending_nxt),
        .pol_high    (irq_pol_high),
        .state_q     (irq_state),
        .irq_o       (irq_o)
    );

    assign reg_rdata = {en_q, st_q};

    // R7: the machine is active exactly when an enabled event is latched
    assert_active_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_state == IRQ_ACTIVE) == (|(st_q & en_q)));

    // R9: masked-only status keeps the line inactive
    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q & en_q) == '0) |-> (irq_state == IRQ_IDLE));

    // R6: a write with no event and no read leaves status untouched
    assert_low_byte_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && (evt_i == '0)) |=> (st_q == $past(st_q)));

endmodule

// File: tb/icsr_top_bench.sv
module icsr_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic        irq_pol_high = 1'b0;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    icsr_top u_icsr_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rd       (reg_rd),
        .reg_rdata    (reg_rdata),
        .irq_pol_high (irq_pol_high),
        .irq_o        (irq_o)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_evt(input logic [7:0] v);
        evt_i = v;
        step();
        evt_i = '0;
    endtask

    task automatic do_read();
        reg_rd = 1'b1;
        step();
        reg_rd = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        step();
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 16'h0000);
        chk("R1 irq", {15'd0, irq_o}, 16'h0001);
    endtask

    task automatic t_event_set();
        pulse_evt(8'h05);
        chk("R2 status", reg_rdata, 16'h0005);
        chk("R9 masked irq", {15'd0, irq_o}, 16'h0001);
    endtask

    task automatic t_sticky();
        step();
        step();
        chk("R3 sticky", reg_rdata, 16'h0005);
    endtask

    task automatic t_read_clear();
        reg_rd = 1'b1;
        #1;
        chk("R4 same-cycle data", reg_rdata, 16'h0005);
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R4 cleared", reg_rdata, 16'h0000);
    endtask

    task automatic t_collision();
        pulse_evt(8'h01);
        reg_rd = 1'b1;
        evt_i = 8'h09;
        #1;
        chk("R5 read shows old", reg_rdata, 16'h0001);
        step();
        reg_rd = 1'b0;
        evt_i = '0;
        chk("R5 kept", reg_rdata, 16'h0009);
        do_read();
        chk("R5 clear after", reg_rdata, 16'h0000);
    endtask

    task automatic t_write();
        do_write(16'h00FF);
        chk("R6 low byte ignored", reg_rdata, 16'h0000);
        pulse_evt(8'h10);
        do_write(16'hA5C3);
        chk("R6 enables loaded", reg_rdata, 16'hA510);
        do_read();
        do_write(16'h0200);
        chk("R6 reload", reg_rdata, 16'h0200);
    endtask

    task automatic t_irq();
        pulse_evt(8'h10);
        chk("R9 masked bit", {15'd0, irq_o}, 16'h0001);
        chk("R9 status", reg_rdata, 16'h0210);
        pulse_evt(8'h02);
        chk("R7 active low", {15'd0, irq_o}, 16'h0000);
        do_read();
        chk("R7 drop", {15'd0, irq_o}, 16'h0001);
        pulse_evt(8'h02);
        chk("R7 re-raise", {15'd0, irq_o}, 16'h0000);
        do_write(16'h0000);
        chk("R7 drop on mask", {15'd0, irq_o}, 16'h0001);
        do_write(16'h0200);
        chk("R7 raise on enable", {15'd0, irq_o}, 16'h0000);
    endtask

    task automatic t_polarity();
        irq_pol_high = 1'b1;
        #1;
        chk("R8 active high", {15'd0, irq_o}, 16'h0001);
        do_read();
        chk("R8 inactive low", {15'd0, irq_o}, 16'h0000);
        irq_pol_high = 1'b0;
        #1;
        chk("R8 inactive high", {15'd0, irq_o}, 16'h0001);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_event_set();
        t_sticky();
        t_read_clear();
        t_collision();
        t_write();
        t_irq();
        t_polarity();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule